// File: doc/BRIEF.md
# DRAM Refresh and Initialization Sequencer

This block keeps an asynchronous DRAM array alive. After reset it holds every strobe inactive for a power-up pause. It then runs a fixed number of warm-up refresh cycles and raises a ready flag. From then on it requests one refresh at a steady interval. Each refresh is a CAS-before-RAS cycle: the column strobes fall first and the row strobe follows. No address is driven, and the write enable stays high throughout.

The block never drives the array on its own initiative. It raises `rfsh_req`, and an external access arbiter answers with `rfsh_gnt`. A cycle starts only on a clock edge where both are high. `rfsh_req` stays high until the row-strobe precharge that ends the cycle has completed, so the arbiter holds the array for the whole cycle.

A refresh that the arbiter does not serve in time is counted by a saturating pending counter. The stored refreshes are later issued one after another. Every timing value is given in nanoseconds and converted to clock cycles from the clock-period parameter. The interval can follow a 2048-row or a 4096-row refresh regime, and the strobe widths can follow a fast or a slow speed grade.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is held, all row and column strobes and the write enable are high, and `rfsh_req` and `ready` are low.
- R2: After reset is released, no strobe moves and `rfsh_req` stays low for T_PAUSE clock edges, where T_PAUSE is PAUSE_NS rounded up to whole clocks. `rfsh_req` rises right after the T_PAUSE-th edge.
- R3: After the pause, exactly WARM_CYCLES refresh cycles run before `ready` rises. Once high, `ready` stays high until reset.
- R4: Once `ready` is high, successive rises of `rfsh_req` are T_INT clocks apart. T_INT is the refresh window divided by the row count and rounded down to whole clocks. The row count is 2048 when REGIME_4K is 0 and 4096 when it is 1.
- R5: Every refresh lowers all column strobes together, T_LEAD clocks before all row strobes fall together. T_LEAD is at least one clock and covers the write-enable guard time. Column and row strobes rise together at the end of the cycle.
- R6: The write enable is high at all times.
- R7: The row strobes stay low for exactly T_RAS clocks. T_RAS is the larger of the minimum strobe width and the minimum cycle time less the precharge, each rounded up. The grade selects 50/90/30 ns when FAST_GRADE is 1 and 60/110/40 ns when it is 0.
- R8: Between two refresh cycles the row strobes stay high for at least T_RP clocks.
- R9: A refresh cycle starts only after an edge where `rfsh_gnt` was high. `rfsh_gnt` has no effect while no refresh is owed.
- R10: Refreshes owed while the grant is withheld are stored up to MAX_PEND and dropped beyond that. When the grant returns, the stored refreshes run back to back, with one idle clock between cycles.
- R11: `rfsh_req` stays high from the start of a cycle until its precharge has ended. It falls only when all strobes are inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rfsh_gnt | input | 1 | Arbiter grants the array to refresh |
| rfsh_req | output | 1 | Refresh owed or in progress |
| ready | output | 1 | Initialization complete |
| ras_n | output | N_RAS | Row strobes, active low |
| cas_n | output | N_CAS | Column strobes, active low |
| we_n | output | 1 | Write enable, active low, held high |

## Verification
The hardest case to reach is pending-counter saturation. It needs several refresh intervals to pass with the grant withheld, and the drain must finish before the next interval tick so that the count of cycles is exact. The bench measures the first periodic request rises to learn the timer phase. It withholds the grant across nine ticks and releases it well before the tenth. It then expects exactly MAX_PEND back-to-back cycles and a request that falls at a known clock.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

   typedef enum logic [1:0] {
      CY_IDLE,
      CY_LEAD,
      CY_ACT,
      CY_PRE
   } cyc_state_e;

   typedef enum logic [1:0] {
      IN_PAUSE,
      IN_WARM,
      IN_RUN
   } init_state_e;

   // nanoseconds to clocks, rounded up
   function automatic int ns_to_cyc(longint ns, longint clk_ps);
      return int'((ns * 64'sd1000 + clk_ps - 64'sd1) / clk_ps);
   endfunction

   // picoseconds to clocks, rounded down (never exceed a deadline)
   function automatic int ps_floor_cyc(longint ps, longint clk_ps);
      return int'(ps / clk_ps);
   endfunction

   function automatic int imax(int a, int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer
   import dram_rfsh_pkg::*;
#(
   parameter longint CLK_PS    = 10000,
   parameter bit     REGIME_4K = 1'b0,
   parameter longint WIN_2K_NS = 32_000_000,
   parameter longint WIN_4K_NS = 64_000_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);

   localparam int     ROWS   = REGIME_4K ? 4096 : 2048;
   localparam longint WIN_NS = REGIME_4K ? WIN_4K_NS : WIN_2K_NS;
   localparam int     T_INT  = ps_floor_cyc((WIN_NS * 64'sd1000) / ROWS, CLK_PS);
   localparam int     CW     = $clog2(T_INT + 1);
   localparam logic [CW-1:0] RELOAD = CW'(T_INT - 1);

   generate
      if (T_INT < 2) begin : g_bad_interval
         $error("refresh interval shorter than two clocks");
      end
   endgenerate

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= RELOAD;
      end else if (!run || cnt == '0) begin
         cnt <= RELOAD;
      end else begin
         cnt <= cnt - CW'(1);
      end
   end

   assign tick = run && (cnt == '0);

   // R4: ticks are spaced at least two clocks apart
   p_tick_spacing_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);

endmodule

// File: rtl/rfsh_pending.sv
module rfsh_pending #(
   parameter int MAX_PEND = 8,
   parameter int WARM     = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic inc,
   input  logic dec,
   output logic nonzero
);

   localparam int PW = $clog2(MAX_PEND + 1);
   localparam logic [PW-1:0] TOP  = PW'(MAX_PEND);
   localparam logic [PW-1:0] SEED = PW'(WARM);

   generate
      if (WARM > MAX_PEND || MAX_PEND < 1) begin : g_bad_depth
         $error("pending depth must hold the warm-up batch");
      end
   endgenerate

   logic [PW-1:0] count;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (load) begin
         count <= SEED;
      end else begin
         unique case ({inc, dec})
            2'b10:   if (count != TOP) count <= count + PW'(1);
            2'b01:   if (count != '0)  count <= count - PW'(1);
            default: count <= count;
         endcase
      end
   end

   assign nonzero = (count != '0);

   p_no_overflow_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      count <= TOP);

   p_no_underflow_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      dec |-> count != '0);

endmodule

// File: rtl/rfsh_cycle_fsm.sv
module rfsh_cycle_fsm
   import dram_rfsh_pkg::*;
#(
   parameter int T_LEAD = 1,
   parameter int T_RAS  = 6,
   parameter int T_RP   = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_ok,
   input  logic gnt,
   output logic strobe_ras_n,
   output logic strobe_cas_n,
   output logic busy,
   output logic done
);

   localparam int TMAX = imax(T_LEAD, imax(T_RAS, T_RP));
   localparam int CW   = $clog2(TMAX + 1);

   generate
      if (T_LEAD < 1 || T_RAS < 1 || T_RP < 1) begin : g_bad_timing
         $error("every refresh phase needs at least one clock");
      end
   endgenerate

   cyc_state_e    st, st_nx;
   logic [CW-1:0] cnt, cnt_nx;

   always_comb begin
      st_nx  = st;
      cnt_nx = cnt;
      unique case (st)
         CY_IDLE: begin
            if (start_ok && gnt) begin
               st_nx  = CY_LEAD;
               cnt_nx = CW'(T_LEAD - 1);
            end
         end
         CY_LEAD: begin
            if (cnt == '0) begin
               st_nx  = CY_ACT;
               cnt_nx = CW'(T_RAS - 1);
            end else begin
               cnt_nx = cnt - CW'(1);
            end
         end
         CY_ACT: begin
            if (cnt == '0) begin
               st_nx  = CY_PRE;
               cnt_nx = CW'(T_RP - 1);
            end else begin
               cnt_nx = cnt - CW'(1);
            end
         end
         CY_PRE: begin
            if (cnt == '0) begin
               st_nx = CY_IDLE;
            end else begin
               cnt_nx = cnt - CW'(1);
            end
         end
         default: st_nx = CY_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st           <= CY_IDLE;
         cnt          <= '0;
         strobe_ras_n <= 1'b1;
         strobe_cas_n <= 1'b1;
      end else begin
         st           <= st_nx;
         cnt          <= cnt_nx;
         strobe_ras_n <= (st_nx != CY_ACT);
         strobe_cas_n <= !((st_nx == CY_LEAD) || (st_nx == CY_ACT));
      end
   end

   assign busy = (st != CY_IDLE);
   assign done = (st == CY_PRE) && (cnt == '0);

   // checker counters for strobe widths
   int low_run, high_run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_run  <= 0;
         high_run <= T_RP;
      end else begin
         low_run  <= strobe_ras_n ? 0 : low_run + 1;
         if (!strobe_ras_n)       high_run <= 0;
         else if (high_run < T_RP) high_run <= high_run + 1;
      end
   end

   p_cas_before_ras_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(strobe_ras_n) |-> !strobe_cas_n && $past(!strobe_cas_n));

   p_ras_low_has_cas_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      !strobe_ras_n |-> !strobe_cas_n);

   p_ras_width_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(strobe_ras_n) |-> low_run == T_RAS);

   p_precharge_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(strobe_ras_n) |-> high_run >= T_RP);

   p_start_needs_gnt_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(strobe_cas_n) |-> $past(gnt) && $past(start_ok));

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
   import dram_rfsh_pkg::*;
#(
   parameter longint CLK_PS       = 10000,
   parameter bit     FAST_GRADE   = 1'b1,
   parameter bit     REGIME_4K    = 1'b0,
   parameter longint PAUSE_NS     = 200_000,
   parameter longint WIN_2K_NS    = 32_000_000,
   parameter longint WIN_4K_NS    = 64_000_000,
   parameter longint WE_GUARD_NS  = 10,
   parameter int     WARM_CYCLES  = 8,
   parameter int     MAX_PEND     = 8,
   parameter int     N_RAS        = 2,
   parameter int     N_CAS        = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rfsh_gnt,
   output logic             rfsh_req,
   output logic             ready,
   output logic [N_RAS-1:0] ras_n,
   output logic [N_CAS-1:0] cas_n,
   output logic             we_n
);

   localparam longint TRP_NS  = FAST_GRADE ? 30 : 40;
   localparam longint TRAS_NS = FAST_GRADE ? 50 : 60;
   localparam longint TRC_NS  = FAST_GRADE ? 90 : 110;
   localparam int T_PAUSE = ns_to_cyc(PAUSE_NS, CLK_PS);
   localparam int T_LEAD  = imax(1, ns_to_cyc(WE_GUARD_NS, CLK_PS));
   localparam int T_RP    = imax(1, ns_to_cyc(TRP_NS, CLK_PS));
   localparam int T_RAS   = imax(ns_to_cyc(TRAS_NS, CLK_PS),
                                 ns_to_cyc(TRC_NS, CLK_PS) - T_RP);
   localparam int PCW     = $clog2(T_PAUSE + 1);
   localparam int WCW     = $clog2(WARM_CYCLES + 1);

   generate
      if (T_PAUSE < 1 || WARM_CYCLES < 1) begin : g_bad_init
         $error("pause and warm-up must be non-empty");
      end
      if (N_RAS < 1 || N_CAS < 1) begin : g_bad_lanes
         $error("at least one row and one column strobe");
      end
   endgenerate

   init_state_e    ist;
   logic [PCW-1:0] pcnt;
   logic [WCW-1:0] wcnt;
   logic           pause_end, tick, pend_any, cyc_busy, cyc_done;
   logic           ras_q, cas_q;

   assign pause_end = (ist == IN_PAUSE) && (pcnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ist  <= IN_PAUSE;
         pcnt <= PCW'(T_PAUSE - 1);
         wcnt <= '0;
      end else begin
         unique case (ist)
            IN_PAUSE: begin
               if (pcnt == '0) ist  <= IN_WARM;
               else            pcnt <= pcnt - PCW'(1);
            end
            IN_WARM: begin
               if (cyc_done) begin
                  if (wcnt == WCW'(WARM_CYCLES - 1)) ist <= IN_RUN;
                  wcnt <= wcnt + WCW'(1);
               end
            end
            default: ist <= ist;
         endcase
      end
   end

   assign ready = (ist == IN_RUN);

   rfsh_interval_timer #(
      .CLK_PS    (CLK_PS),
      .REGIME_4K (REGIME_4K),
      .WIN_2K_NS (WIN_2K_NS),
      .WIN_4K_NS (WIN_4K_NS)
   ) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (ready),
      .tick  (tick)
   );

   rfsh_pending #(
      .MAX_PEND (MAX_PEND),
      .WARM     (WARM_CYCLES)
   ) u_pending (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (pause_end),
      .inc     (tick),
      .dec     (cyc_done),
      .nonzero (pend_any)
   );

   rfsh_cycle_fsm #(
      .T_LEAD (T_LEAD),
      .T_RAS  (T_RAS),
      .T_RP   (T_RP)
   ) u_cycle (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_ok     (pend_any),
      .gnt          (rfsh_gnt),
      .strobe_ras_n (ras_q),
      .strobe_cas_n (cas_q),
      .busy         (cyc_busy),
      .done         (cyc_done)
   );

   assign rfsh_req = pend_any | cyc_busy;
   assign we_n     = 1'b1;

   for (genvar g = 0; g < N_RAS; g++) begin : g_ras_fan
      assign ras_n[g] = ras_q;
   end
   for (genvar g = 0; g < N_CAS; g++) begin : g_cas_fan
      assign cas_n[g] = cas_q;
   end

   // checker: row-strobe rises seen before ready
   logic ras_prev;
   int   rises_seen;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ras_prev   <= 1'b1;
         rises_seen <= 0;
      end else begin
         ras_prev <= ras_q;
         if (!ras_prev && ras_q && !ready) rises_seen <= rises_seen + 1;
      end
   end

   p_quiet_pause_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      (ist == IN_PAUSE) |-> (&ras_n) && (&cas_n) && !rfsh_req);

   p_ready_sticky_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      ready |=> ready);

   p_ready_after_warm_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> rises_seen == WARM_CYCLES);

   p_req_release_r11 : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rfsh_req) |-> (&ras_n) && (&cas_n));

endmodule

// File: tb/tb_dram_refresh_seq.sv
module tb_dram_refresh_seq;

   localparam int CLK_NS  = 10;
   localparam int N_RAS   = 2;
   localparam int N_CAS   = 4;
   localparam int T_PAUSE = 100;
   localparam int T_INT   = 200;
   localparam int T_LEAD  = 1;
   localparam int T_RAS   = 6;
   localparam int T_RP    = 3;
   localparam int WARM    = 8;
   localparam int MAXP    = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             rfsh_gnt = 1'b0;
   logic             rfsh_req, ready, we_n;
   logic [N_RAS-1:0] ras_n;
   logic [N_CAS-1:0] cas_n;

   always #(CLK_NS / 2) clk = ~clk;

   dram_refresh_seq #(
      .CLK_PS      (CLK_NS * 1000),
      .FAST_GRADE  (1'b1),
      .REGIME_4K   (1'b0),
      .PAUSE_NS    (T_PAUSE * CLK_NS),
      .WIN_2K_NS   (2048 * T_INT * CLK_NS),
      .WIN_4K_NS   (4096 * T_INT * CLK_NS),
      .WE_GUARD_NS (10),
      .WARM_CYCLES (WARM),
      .MAX_PEND    (MAXP),
      .N_RAS       (N_RAS),
      .N_CAS       (N_CAS)
   ) dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .rfsh_gnt (rfsh_gnt),
      .rfsh_req (rfsh_req),
      .ready    (ready),
      .ras_n    (ras_n),
      .cas_n    (cas_n),
      .we_n     (we_n)
   );

   int n_cmp = 0, n_bad = 0, cyc = 0;
   bit finished = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   typedef struct {
      int lead;
      int low;
   } shape_t;
   shape_t exp_q[$];

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int expv);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   // monitor: measures every refresh cycle and pops the scoreboard
   bit prev_c = 1'b1, prev_r = 1'b1, seen_rise = 1'b0;
   bit we_bad = 1'b0, lane_bad = 1'b0;
   int lead_n = 0, low_n = 0, hi_n = 0, cas_falls = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (we_n !== 1'b1) we_bad = 1'b1;
         if (cas_n !== {N_CAS{cas_n[0]}} || ras_n !== {N_RAS{ras_n[0]}})
            lane_bad = 1'b1;
         if (prev_c && !cas_n[0]) begin
            cas_falls++;
            lead_n = 0;
            low_n  = 0;
            chk(rfsh_gnt == 1'b1, "R9", "grant at cycle start", int'(rfsh_gnt), 1);
         end
         if (!cas_n[0] && ras_n[0]) lead_n++;
         if (!ras_n[0]) low_n++;
         if (prev_r && !ras_n[0]) begin
            if (seen_rise)
               chk(hi_n >= T_RP, "R8", "row precharge clocks", hi_n, T_RP);
            chk(!cas_n[0], "R5", "column low at row fall", int'(cas_n[0]), 0);
         end
         if (ras_n[0]) begin
            if (!prev_r) hi_n = 1;
            else         hi_n++;
         end
         if (!prev_r && ras_n[0]) begin
            seen_rise = 1'b1;
            chk(cas_n[0] == 1'b1, "R5", "column released with row", int'(cas_n[0]), 1);
            if (exp_q.size() == 0) begin
               chk(1'b0, "R7", "unexpected refresh cycle", 1, 0);
            end else begin
               shape_t e;
               e = exp_q.pop_front();
               chk(lead_n == e.lead, "R5", "column lead clocks", lead_n, e.lead);
               chk(low_n == e.low, "R7", "row low clocks", low_n, e.low);
            end
         end
         prev_c = cas_n[0];
         prev_r = ras_n[0];
      end
   end

   task automatic wait_req_rise(output int t);
      logic pv;
      pv = rfsh_req;
      t  = -1;
      for (int k = 0; k < 1000; k++) begin
         @(negedge clk);
         if (!pv && rfsh_req) begin
            t = cyc;
            return;
         end
         pv = rfsh_req;
      end
   endtask

   task automatic wait_until(input int target);
      while (cyc < target) @(negedge clk);
   endtask

   // driver
   initial begin
      int r0, r1, r2, base, rel, guard;
      repeat (3) @(negedge clk);
      chk(ras_n == '1, "R1", "row strobes in reset", int'(ras_n), 3);
      chk(cas_n == '1, "R1", "column strobes in reset", int'(cas_n), 15);
      chk(we_n == 1'b1, "R1", "write enable in reset", int'(we_n), 1);
      chk(rfsh_req == 1'b0, "R1", "request in reset", int'(rfsh_req), 0);
      chk(ready == 1'b0, "R1", "ready in reset", int'(ready), 0);

      for (int i = 0; i < WARM; i++) exp_q.push_back('{T_LEAD, T_RAS});
      rst_n    = 1'b1;
      rfsh_gnt = 1'b1;   // grant offered early: must be ignored (R9)

      repeat (T_PAUSE - 1) @(negedge clk);
      chk(rfsh_req == 1'b0, "R2", "request during pause", int'(rfsh_req), 0);
      chk(cas_falls == 0, "R2", "cycles during pause", cas_falls, 0);
      @(negedge clk);
      chk(rfsh_req == 1'b1, "R2", "request after pause", int'(rfsh_req), 1);

      guard = 0;
      while (!ready && guard < 2000) begin
         @(negedge clk);
         guard++;
      end
      chk(ready == 1'b1, "R3", "ready after warm-up", int'(ready), 1);
      chk(cas_falls == WARM, "R3", "warm-up cycles before ready", cas_falls, WARM);

      wait_req_rise(r0);
      exp_q.push_back('{T_LEAD, T_RAS});
      wait_req_rise(r1);
      exp_q.push_back('{T_LEAD, T_RAS});
      wait_req_rise(r2);
      exp_q.push_back('{T_LEAD, T_RAS});
      chk(r1 - r0 == T_INT, "R4", "request spacing 1", r1 - r0, T_INT);
      chk(r2 - r1 == T_INT, "R4", "request spacing 2", r2 - r1, T_INT);

      // withhold the grant across nine ticks, release before the tenth
      wait_until(r2 + 100);
      rfsh_gnt = 1'b0;
      base = cas_falls;
      wait_until(r2 + 1850);
      chk(cas_falls == base, "R9", "cycles while grant withheld", cas_falls - base, 0);
      chk(rfsh_req == 1'b1, "R10", "request while starved", int'(rfsh_req), 1);
      for (int i = 0; i < MAXP; i++) exp_q.push_back('{T_LEAD, T_RAS});
      rfsh_gnt = 1'b1;
      rel = cyc;
      wait_until(rel + 80);
      chk(rfsh_req == 1'b1, "R11", "request held through drain", int'(rfsh_req), 1);
      wait_until(rel + 95);
      chk(rfsh_req == 1'b0, "R10", "request after back-to-back drain", int'(rfsh_req), 0);
      chk(cas_falls - base == MAXP, "R10", "stored cycles issued", cas_falls - base, MAXP);

      chk(ready == 1'b1, "R3", "ready stays high", int'(ready), 1);
      chk(exp_q.size() == 0, "R7", "expected cycles left over", exp_q.size(), 0);
      chk(!we_bad, "R6", "write enable left high", int'(we_bad), 0);
      chk(!lane_bad, "R5", "strobe lanes move together", int'(lane_bad), 0);

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 20000);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule